// File: doc/BRIEF.md
# PLL Divider Programming Register Set

This block is the programming front end of an integer-N synthesizer. It holds three registers. A 20-bit working word is loaded from the host. A 20-bit standby word receives a copy of the working word on command. An 8-bit option register completes the set. The block drives the divider chain with one 20-bit counter word and exposes the option bits. The host may load the working word over a three-wire serial port, with data shifted in most significant bit first. It may instead load the word in slices from an 8-bit parallel bus, with one write strobe per slice.

Three operating modes are available. In serial mode and in parallel mode, a select input chooses which word feeds the counters: the working word or the standby word. A host can therefore prepare the next frequency in the working word while the standby word drives the counters. A single hop strobe then swaps the frequency in one step. In direct mode, the registers are frozen and the counter word comes straight from the bus and two 4-bit pin groups.

All pins are registered once in the system clock domain before use. Every strobe and the serial clock act on their rising edge, which the block detects synchronously.

Top module: `pll_prog_regs`

## Requirements
- R1: After reset all three registers are zero, so `ctr_word` and `enh_out` read zero.
- R2: The counter word is laid out as bit 19 = prescaler enable, bits 18:10 = main count M[8:0], bits 9:4 = reference count R[5:0] and bits 3:0 = swallow count A[3:0]. The serial mode is selected by `sel_direct`=0 and `sel_serial`=1. In serial mode, with `sload_n` low and `enh_wsel` low, each rising edge of `sclk_in` shifts `sdata_in` into bit 0 of the working word and moves the other bits up one place. A word sent most significant bit first therefore lands unchanged.
- R3: In serial mode, with `sload_n` low and `enh_wsel` high, `sclk_in` rising edges shift `sdata_in` into the 8-bit option register in the same way, and the working word is left unchanged.
- R4: In serial mode, `sclk_in` edges have no effect while `sload_n` is high.
- R5: The working word is copied into the standby word on a rising edge of `sload_n` in serial mode, or on a rising edge of `wr_hop` in serial or parallel mode. No other event changes the standby word.
- R6: The parallel mode is selected by `sel_direct`=0 and `sel_serial`=0. In parallel mode, the rising edge of each write strobe copies a slice of `pbus` into the working word. `wr_main_lo` writes pbus[7] to the prescaler enable and pbus[6:0] to M[6:0]. `wr_main_hi` writes pbus[3:2] to R[5:4] and pbus[1:0] to M[8:7]. `wr_ref_swl` writes pbus[7:4] to R[3:0] and pbus[3:0] to A[3:0]. All other fields keep their values.
- R7: In parallel mode, a rising edge of `enh_wsel` loads `pbus` into the option register.
- R8: In serial mode `pick_ser` chooses which word drives `ctr_word`, and in parallel mode `pick_par` does: 1 selects the working word and 0 selects the standby word. The select input of the other mode has no effect.
- R9: When `sel_direct`=1 the block is in direct mode, and `ctr_word` = {pbus[7], 2'b00, pbus[6:0], 2'b00, dir_ref, dir_swl}. Strobes and serial clock edges leave all registers unchanged in this mode.
- R10: `enh_out` equals the option register while `enh_en_n` is low, and reads zero while it is high.
- R11: A rising strobe edge applied just before clock edge k first shows on `ctr_word` after clock edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_direct | input | 1 | 1 selects direct mode |
| sel_serial | input | 1 | With sel_direct=0: 1 serial, 0 parallel |
| sclk_in | input | 1 | Serial shift clock |
| sdata_in | input | 1 | Serial data, MSB first |
| sload_n | input | 1 | Serial load strobe; shift while low, transfer on rise |
| enh_wsel | input | 1 | Serial: option-register target; parallel: option write strobe |
| pbus | input | 8 | Parallel data bus, also direct-mode M and prescaler pins |
| wr_main_lo | input | 1 | Parallel strobe for prescaler enable and M[6:0] |
| wr_main_hi | input | 1 | Parallel strobe for R[5:4] and M[8:7] |
| wr_ref_swl | input | 1 | Parallel strobe for R[3:0] and A[3:0] |
| wr_hop | input | 1 | Working-to-standby transfer strobe |
| pick_ser | input | 1 | Word select in serial mode |
| pick_par | input | 1 | Word select in parallel mode |
| enh_en_n | input | 1 | Active-low option-bit enable |
| dir_ref | input | 4 | Direct-mode R[3:0] |
| dir_swl | input | 4 | Direct-mode A[3:0] |
| ctr_word | output | 20 | Active counter word |
| enh_out | output | 8 | Gated option bits |

## Verification
On every cycle, the assertions check the register-level rules. A serial clock edge must shift exactly one bit into the targeted register. Shifting must be blocked while the load strobe is high. The standby word may change only on a transfer edge, and it must then equal the prior working word. Direct mode must leave the registers frozen. The option output must be gated, and the serial-mode word select must be obeyed.

Other behaviour only the bench scenarios can show. These include the field mapping of each parallel strobe over every bus value, and the bit order of complete serial words. They also include the direct-mode pin assembly, that frozen registers survive a return to parallel mode, and the exact two-cycle strobe latency.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;
    localparam int PRE_W   = 1;
    localparam int M_W     = 9;
    localparam int R_W     = 6;
    localparam int A_W     = 4;
    localparam int WORD_W  = PRE_W + M_W + R_W + A_W;
    localparam int BUS_W   = 8;
    localparam int ENH_W   = BUS_W;
    localparam int M_LO_W  = BUS_W - PRE_W;
    localparam int M_HI_W  = M_W - M_LO_W;
    localparam int R_LO_W  = BUS_W - A_W;
    localparam int R_HI_W  = R_W - R_LO_W;

    localparam int STB_SCLK  = 0;
    localparam int STB_SLOAD = 1;
    localparam int STB_ESEL  = 2;
    localparam int STB_M1    = 3;
    localparam int STB_M2    = 4;
    localparam int STB_A     = 5;
    localparam int STB_HOP   = 6;
    localparam int STB_N     = 7;

    typedef struct packed {
        logic             pre_en;
        logic [M_W-1:0]   m;
        logic [R_W-1:0]   r;
        logic [A_W-1:0]   a;
    } ctr_word_t;

    typedef enum logic [1:0] {
        MODE_PAR = 2'd0,
        MODE_SER = 2'd1,
        MODE_DIR = 2'd2
    } if_mode_t;
endpackage

// File: rtl/prog_edge_sync.sv
module prog_edge_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    typedef struct packed {
        logic [W-1:0] cur;
        logic [W-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.cur  = raw;
        s_d.prev = s_q.cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl  = s_q.cur;
    assign rise = s_q.cur & ~s_q.prev;
endmodule

// File: rtl/prog_word_regs.sv
module prog_word_regs
    import pll_prog_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  if_mode_t                mode,
    input  logic [STB_N-1:0]        lvl,
    input  logic [STB_N-1:0]        rise,
    input  logic                    ser_bit,
    input  logic [BUS_W-1:0]        bus,
    output ctr_word_t               prim,
    output ctr_word_t               sec,
    output logic [ENH_W-1:0]        enh
);
    typedef struct packed {
        ctr_word_t          prim;
        ctr_word_t          sec;
        logic [ENH_W-1:0]   enh;
    } regs_t;

    regs_t s_d, s_q;
    logic  is_ser, is_par, shift_ok;

    always_comb begin
        s_d      = s_q;
        is_ser   = (mode == MODE_SER);
        is_par   = (mode == MODE_PAR);
        shift_ok = is_ser && rise[STB_SCLK] && !lvl[STB_SLOAD];

        if (shift_ok) begin
            if (lvl[STB_ESEL]) s_d.enh  = {s_q.enh[ENH_W-2:0], ser_bit};
            else               s_d.prim = ctr_word_t'({s_q.prim[WORD_W-2:0], ser_bit});
        end

        if (is_par) begin
            if (rise[STB_M1])
                {s_d.prim.pre_en, s_d.prim.m[M_LO_W-1:0]} = bus;
            if (rise[STB_M2])
                {s_d.prim.r[R_W-1:R_LO_W], s_d.prim.m[M_W-1:M_LO_W]} = bus[R_HI_W+M_HI_W-1:0];
            if (rise[STB_A])
                {s_d.prim.r[R_LO_W-1:0], s_d.prim.a} = bus;
            if (rise[STB_ESEL])
                s_d.enh = bus;
        end

        if ((is_ser && rise[STB_SLOAD]) || ((is_ser || is_par) && rise[STB_HOP]))
            s_d.sec = s_q.prim;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign prim = s_q.prim;
    assign sec  = s_q.sec;
    assign enh  = s_q.enh;
endmodule

// File: rtl/prog_word_mux.sv
module prog_word_mux
    import pll_prog_pkg::*;
(
    input  if_mode_t             mode,
    input  logic                 pick_ser,
    input  logic                 pick_par,
    input  logic                 enh_en_n,
    input  ctr_word_t            prim,
    input  ctr_word_t            sec,
    input  logic [ENH_W-1:0]     enh,
    input  logic [BUS_W-1:0]     bus,
    input  logic [R_LO_W-1:0]    dir_ref,
    input  logic [A_W-1:0]       dir_swl,
    output ctr_word_t            word,
    output logic [ENH_W-1:0]     enh_out
);
    always_comb begin
        unique case (mode)
            MODE_SER: word = pick_ser ? prim : sec;
            MODE_PAR: word = pick_par ? prim : sec;
            default: begin
                word.pre_en = bus[BUS_W-1];
                word.m      = {{M_HI_W{1'b0}}, bus[M_LO_W-1:0]};
                word.r      = {{R_HI_W{1'b0}}, dir_ref};
                word.a      = dir_swl;
            end
        endcase
        enh_out = enh_en_n ? '0 : enh;
    end
endmodule

// File: rtl/pll_prog_regs.sv
module pll_prog_regs
    import pll_prog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_direct,
    input  logic                 sel_serial,
    input  logic                 sclk_in,
    input  logic                 sdata_in,
    input  logic                 sload_n,
    input  logic                 enh_wsel,
    input  logic [BUS_W-1:0]     pbus,
    input  logic                 wr_main_lo,
    input  logic                 wr_main_hi,
    input  logic                 wr_ref_swl,
    input  logic                 wr_hop,
    input  logic                 pick_ser,
    input  logic                 pick_par,
    input  logic                 enh_en_n,
    input  logic [R_LO_W-1:0]    dir_ref,
    input  logic [A_W-1:0]       dir_swl,
    output logic [WORD_W-1:0]    ctr_word,
    output logic [ENH_W-1:0]     enh_out
);
    typedef struct packed {
        logic                 direct;
        logic                 serial;
        logic                 sdata;
        logic [BUS_W-1:0]     bus;
        logic [R_LO_W-1:0]    dref;
        logic [A_W-1:0]       dswl;
        logic                 pk_ser;
        logic                 pk_par;
        logic                 enh_n;
    } pins_t;

    pins_t            in_d, in_q;
    if_mode_t         mode_w;
    logic [STB_N-1:0] stb_raw, lvl_w, rise_w;
    ctr_word_t        prim_w, sec_w, word_w;
    logic [ENH_W-1:0] enh_w;

    always_comb begin
        in_d = '{direct: sel_direct, serial: sel_serial, sdata: sdata_in,
                 bus: pbus, dref: dir_ref, dswl: dir_swl,
                 pk_ser: pick_ser, pk_par: pick_par, enh_n: enh_en_n};
        if (in_q.direct)      mode_w = MODE_DIR;
        else if (in_q.serial) mode_w = MODE_SER;
        else                  mode_w = MODE_PAR;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= in_d;
    end

    always_comb begin
        stb_raw            = '0;
        stb_raw[STB_SCLK]  = sclk_in;
        stb_raw[STB_SLOAD] = sload_n;
        stb_raw[STB_ESEL]  = enh_wsel;
        stb_raw[STB_M1]    = wr_main_lo;
        stb_raw[STB_M2]    = wr_main_hi;
        stb_raw[STB_A]     = wr_ref_swl;
        stb_raw[STB_HOP]   = wr_hop;
    end

    prog_edge_sync #(.W(STB_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(stb_raw), .lvl(lvl_w), .rise(rise_w)
    );

    prog_word_regs u_regs (
        .clk(clk), .rst_n(rst_n), .mode(mode_w), .lvl(lvl_w), .rise(rise_w),
        .ser_bit(in_q.sdata), .bus(in_q.bus),
        .prim(prim_w), .sec(sec_w), .enh(enh_w)
    );

    prog_word_mux u_mux (
        .mode(mode_w), .pick_ser(in_q.pk_ser), .pick_par(in_q.pk_par),
        .enh_en_n(in_q.enh_n), .prim(prim_w), .sec(sec_w), .enh(enh_w),
        .bus(in_q.bus), .dir_ref(in_q.dref), .dir_swl(in_q.dswl),
        .word(word_w), .enh_out(enh_out)
    );

    assign ctr_word = word_w;
endmodule

// File: rtl/pll_prog_chk.sv
module pll_prog_chk
    import pll_prog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode,
    input  logic [STB_N-1:0]     lvl,
    input  logic [STB_N-1:0]     rise,
    input  logic                 ser_bit,
    input  logic                 pk_ser,
    input  logic                 enh_n,
    input  logic [WORD_W-1:0]    prim,
    input  logic [WORD_W-1:0]    sec,
    input  logic [ENH_W-1:0]     enh,
    input  logic [WORD_W-1:0]    ctr_word,
    input  logic [ENH_W-1:0]     enh_out
);
    logic ser_m, dir_m;
    assign ser_m = (mode == MODE_SER);
    assign dir_m = (mode == MODE_DIR);

    p_shift_prim_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_m && rise[STB_SCLK] && !lvl[STB_SLOAD] && !lvl[STB_ESEL])
        |=> prim == {$past(prim[WORD_W-2:0]), $past(ser_bit)});

    p_shift_enh_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_m && rise[STB_SCLK] && !lvl[STB_SLOAD] && lvl[STB_ESEL])
        |=> (enh == {$past(enh[ENH_W-2:0]), $past(ser_bit)}) && $stable(prim));

    p_load_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_m && lvl[STB_SLOAD]) |=> $stable(prim));

    p_hop_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_m && rise[STB_HOP]) |=> sec == $past(prim));

    p_sec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise[STB_HOP] && !rise[STB_SLOAD]) |=> $stable(sec));

    p_pick_ser_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_m |-> ctr_word == (pk_ser ? prim : sec));

    p_direct_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dir_m |=> $stable(prim) && $stable(sec) && $stable(enh));

    p_enh_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        enh_n |-> enh_out == '0);
endmodule

bind pll_prog_regs pll_prog_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode_w), .lvl(lvl_w), .rise(rise_w),
    .ser_bit(in_q.sdata), .pk_ser(in_q.pk_ser), .enh_n(in_q.enh_n),
    .prim(prim_w), .sec(sec_w), .enh(enh_w),
    .ctr_word(ctr_word), .enh_out(enh_out)
);

// File: tb/pll_prog_regs_bench.sv
`timescale 1ns/1ps
module pll_prog_regs_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_direct = 0, sel_serial = 0, sclk_in = 0, sdata_in = 0, sload_n = 0;
    logic enh_wsel = 0, wr_main_lo = 0, wr_main_hi = 0, wr_ref_swl = 0, wr_hop = 0;
    logic pick_ser = 0, pick_par = 0, enh_en_n = 0;
    logic [7:0]  pbus = '0;
    logic [3:0]  dir_ref = '0, dir_swl = '0;
    logic [19:0] ctr_word;
    logic [7:0]  enh_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [19:0] exp_prim = '0, exp_sec = '0;
    logic [7:0]  exp_enh = '0;

    always #2 clk = ~clk;

    pll_prog_regs u_pll_prog_regs (
        .clk(clk), .rst_n(rst_n), .sel_direct(sel_direct), .sel_serial(sel_serial),
        .sclk_in(sclk_in), .sdata_in(sdata_in), .sload_n(sload_n), .enh_wsel(enh_wsel),
        .pbus(pbus), .wr_main_lo(wr_main_lo), .wr_main_hi(wr_main_hi),
        .wr_ref_swl(wr_ref_swl), .wr_hop(wr_hop), .pick_ser(pick_ser),
        .pick_par(pick_par), .enh_en_n(enh_en_n), .dir_ref(dir_ref),
        .dir_swl(dir_swl), .ctr_word(ctr_word), .enh_out(enh_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic shift_bits(input logic [19:0] val, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdata_in = val[i];
            sclk_in  = 1'b0;
            tick(2);
            sclk_in  = 1'b1;
            tick(2);
        end
        sclk_in = 1'b0;
        tick(2);
    endtask

    task automatic pulse(input int which);
        case (which)
            0: wr_main_lo = 1'b1;
            1: wr_main_hi = 1'b1;
            2: wr_ref_swl = 1'b1;
            3: wr_hop     = 1'b1;
            default: enh_wsel = 1'b1;
        endcase
        tick(3);
        wr_main_lo = 0; wr_main_hi = 0; wr_ref_swl = 0; wr_hop = 0; enh_wsel = 0;
        tick(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [19:0] w;
        logic [7:0]  v;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        chk("R1 ctr_word", {12'b0, ctr_word}, 32'h0);
        chk("R1 enh_out", {24'b0, enh_out}, 32'h0);

        // Serial mode: one-hot and arithmetic words
        sel_serial = 1'b1;
        pick_ser   = 1'b1;
        tick(3);
        for (int k = 0; k < 24; k++) begin
            w = (k < 20) ? (20'h1 << k) : 20'((k * 32'h3B5A7 + 32'h1234) & 32'hFFFFF);
            sload_n = 1'b0;
            tick(2);
            shift_bits(w, 20);
            exp_prim = w;
            chk("R2 serial word", {12'b0, ctr_word}, {12'b0, exp_prim});
            sload_n = 1'b1;
            tick(3);
            exp_sec = exp_prim;
            pick_ser = 1'b0;
            tick(2);
            chk("R5 serial transfer", {12'b0, ctr_word}, {12'b0, exp_sec});
            pick_ser = 1'b1;
            shift_bits(~w, 3);
            chk("R4 shift blocked", {12'b0, ctr_word}, {12'b0, exp_prim});
            pick_par = 1'b0;
            tick(2);
            chk("R8 serial ignores pick_par", {12'b0, ctr_word}, {12'b0, exp_prim});
        end
        sload_n = 1'b0;
        tick(3);

        // R3: serial option register
        enh_wsel = 1'b1;
        tick(3);
        for (int k = 0; k < 16; k++) begin
            v = 8'(k * 37 + 5);
            shift_bits({12'b0, v}, 8);
            exp_enh = v;
            chk("R3 serial enh", {24'b0, enh_out}, {24'b0, exp_enh});
            chk("R3 prim untouched", {12'b0, ctr_word}, {12'b0, exp_prim});
        end
        enh_en_n = 1'b1;
        tick(2);
        chk("R10 gated off", {24'b0, enh_out}, 32'h0);
        enh_en_n = 1'b0;
        tick(2);
        chk("R10 gated on", {24'b0, enh_out}, {24'b0, exp_enh});
        enh_wsel = 1'b0;
        tick(3);

        // Parallel mode sweeps
        sel_serial = 1'b0;
        pick_par   = 1'b1;
        pick_ser   = 1'b0;
        tick(3);
        chk("R8 parallel pick_par", {12'b0, ctr_word}, {12'b0, exp_prim});
        for (int k = 0; k < 256; k++) begin
            pbus = 8'(k);
            tick(1);
            pulse(0);
            exp_prim[19] = pbus[7];
            exp_prim[16:10] = pbus[6:0];
            chk("R6 main_lo", {12'b0, ctr_word}, {12'b0, exp_prim});
        end
        for (int k = 0; k < 16; k++) begin
            pbus = 8'(k) | 8'hF0;
            tick(1);
            pulse(1);
            exp_prim[18:17] = pbus[1:0];
            exp_prim[9:8]   = pbus[3:2];
            chk("R6 main_hi", {12'b0, ctr_word}, {12'b0, exp_prim});
        end
        for (int k = 0; k < 256; k++) begin
            pbus = 8'(255 - k);
            tick(1);
            pulse(2);
            exp_prim[7:4] = pbus[7:4];
            exp_prim[3:0] = pbus[3:0];
            chk("R6 ref_swl", {12'b0, ctr_word}, {12'b0, exp_prim});
        end
        pick_par = 1'b0;
        tick(2);
        chk("R5 standby held", {12'b0, ctr_word}, {12'b0, exp_sec});
        pulse(3);
        exp_sec = exp_prim;
        chk("R5 hop transfer", {12'b0, ctr_word}, {12'b0, exp_sec});
        pick_par = 1'b1;

        for (int k = 0; k < 8; k++) begin
            pbus = 8'(k * 53 + 17);
            tick(1);
            pulse(4);
            exp_enh = pbus;
            chk("R7 parallel enh", {24'b0, enh_out}, {24'b0, exp_enh});
        end

        // R11: exact latency
        pbus = 8'h5A;
        tick(2);
        wr_ref_swl = 1'b1;
        tick(1);
        chk("R11 not yet", {12'b0, ctr_word}, {12'b0, exp_prim});
        tick(1);
        exp_prim[7:0] = 8'h5A;
        chk("R11 after two edges", {12'b0, ctr_word}, {12'b0, exp_prim});
        wr_ref_swl = 1'b0;
        tick(3);

        // R9: direct mode
        sel_direct = 1'b1;
        for (int k = 0; k < 256; k++) begin
            v = 8'(k);
            pbus = v;
            dir_ref = v[3:0] ^ v[7:4];
            dir_swl = ~v[3:0];
            tick(2);
            chk("R9 direct word", {12'b0, ctr_word},
                {12'b0, v[7], 2'b00, v[6:0], 2'b00, v[3:0] ^ v[7:4], ~v[3:0]});
        end
        pbus = 8'hFF;
        tick(1);
        pulse(0); pulse(1); pulse(2); pulse(3); pulse(4);
        sload_n = 1'b1; sclk_in = 1'b1;
        tick(3);
        sel_direct = 1'b0;
        tick(3);
        chk("R9 prim frozen", {12'b0, ctr_word}, {12'b0, exp_prim});
        chk("R9 enh frozen", {24'b0, enh_out}, {24'b0, exp_enh});
        pick_par = 1'b0;
        tick(2);
        chk("R9 sec frozen", {12'b0, ctr_word}, {12'b0, exp_sec});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule